// File: doc/BRIEF.md
# Transaction ID Capture and Completion Header Builder

This block holds the identity of one endpoint function and forms the header of every completion that the function returns. It watches decoded inbound requests. When the function accepts a Type 0 configuration write, the block takes the bus and device numbers carried in that write and keeps them. From then on it uses those numbers for two things. They form the requester identity that the function places on the requests it starts. They also form the completer identity on each completion the function returns. The function number comes from a fixed input.

Each non-posted request produces one completion descriptor. The descriptor repeats the request's requester identity, tag, attribute bits and traffic class without change, for any traffic class value. A request kind the function does not support receives an Unsupported Request status. Posted kinds produce no descriptor. The descriptor leaves through a valid/ready handshake and stays stable while the consumer holds it back.

The control is a two-state machine. In `IDLE` the block accepts requests (`req_ready` high). The transition `ACCEPT_NP` (a non-posted request is accepted) captures the descriptor and moves to `HOLD`. The transition `ACCEPT_P` (a posted request is accepted) stays in `IDLE`. In `HOLD` the descriptor is offered on `cpl_valid` and `req_ready` is low. The transition `STALL` (`cpl_ready` low) stays in `HOLD`. The transition `RELEASE` (`cpl_ready` high) returns to `IDLE`.

Top module: `txid_cpl_top`

## Requirements
- R1: After reset, `own_req_id` equals {8'h00, 5'h00, func_num}, `cpl_valid` is 0 and `req_ready` is 1.
- R2: An accepted request of kind 3 (Type 0 configuration write) stores `req_cfg_bus` and `req_cfg_dev`, and they appear from the next cycle on. A request of any other kind leaves the stored numbers unchanged.
- R3: `own_req_id` is {stored bus in bits 15:8, stored device in bits 7:3, `func_num` in bits 2:0} at all times.
- R4: `cpl_cid` uses the same layout as `own_req_id` and is built from the stored numbers as they were when the request was accepted. For a kind 3 request it uses the numbers carried by that write.
- R5: `cpl_rid`, `cpl_tag`, `cpl_attr` and `cpl_tc` equal the request's `req_rid`, `req_tag`, `req_attr` and `req_tc` for every traffic class value from 0 to 7.
- R6: The kind codes are: 0 memory read, 2 Type 0 configuration read, 3 Type 0 configuration write, 5 I/O read, 6 I/O write (all non-posted), and 1 memory write, 4 message, 7 vendor message (all posted). A posted kind never raises `cpl_valid`.
- R7: Kinds 0, 2 and 3 are supported and return status 3'b000. Kinds 5 and 6 are unsupported and return status 3'b001 (UR). `cpl_has_data` is 1 only for kinds 0 and 2.
- R8: An accepted non-posted request raises `cpl_valid` in the next cycle, and exactly one descriptor is produced for it. `req_ready` is 0 while `cpl_valid` is 1.
- R9: While `cpl_valid` is 1 and `cpl_ready` is 0, every descriptor output holds its value into the next cycle. The handshake on `cpl_ready` drops `cpl_valid` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| func_num | input | 3 | Fixed function number |
| req_valid | input | 1 | Decoded inbound request present |
| req_ready | output | 1 | Block can take a request |
| req_kind | input | 3 | Request kind code |
| req_rid | input | 16 | Requester ID of the request |
| req_tag | input | 8 | Tag of the request |
| req_attr | input | 2 | Attribute bits of the request |
| req_tc | input | 3 | Traffic class of the request |
| req_cfg_bus | input | 8 | Bus number carried by a configuration write |
| req_cfg_dev | input | 5 | Device number carried by a configuration write |
| own_req_id | output | 16 | Requester ID for requests the function starts |
| cpl_valid | output | 1 | Completion descriptor present |
| cpl_ready | input | 1 | Consumer takes the descriptor |
| cpl_cid | output | 16 | Completer ID |
| cpl_rid | output | 16 | Echoed requester ID |
| cpl_tag | output | 8 | Echoed tag |
| cpl_attr | output | 2 | Echoed attributes |
| cpl_tc | output | 3 | Echoed traffic class |
| cpl_status | output | 3 | 3'b000 success, 3'b001 unsupported |
| cpl_has_data | output | 1 | Completion carries data |

## Verification
A stored bus or device number that is wrong shows up on `own_req_id` in the cycle after the configuration write. It also shows up on `cpl_cid` of the next completion. A state machine stuck in the wrong state shows up in the same cycle, because `req_ready` and `cpl_valid` are driven directly from the state. A descriptor captured from the wrong fields, or changed while the consumer stalls, shows up on the descriptor ports from the first cycle after acceptance. The bench checks each of these outputs on every stalled cycle, for every request kind and every traffic class.

// File: rtl/txid_pkg.sv
package txid_pkg;
    typedef enum logic [2:0] {
        K_MEM_RD  = 3'd0,
        K_MEM_WR  = 3'd1,
        K_CFG_RD0 = 3'd2,
        K_CFG_WR0 = 3'd3,
        K_MSG     = 3'd4,
        K_IO_RD   = 3'd5,
        K_IO_WR   = 3'd6,
        K_VMSG    = 3'd7
    } req_kind_e;

    localparam logic [2:0] CST_SC = 3'b000;
    localparam logic [2:0] CST_UR = 3'b001;

    typedef struct packed {
        logic needs_cpl;
        logic supported;
        logic with_data;
        logic learns_id;
    } kind_info_t;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_HOLD = 1'b1
    } cpl_state_e;
endpackage

// File: rtl/txid_classify.sv
module txid_classify
    import txid_pkg::*;
(
    input  logic [2:0] kind,
    output kind_info_t info
);
    always_comb begin
        info = '0;
        unique case (req_kind_e'(kind))
            K_MEM_RD:  info = '{needs_cpl: 1'b1, supported: 1'b1, with_data: 1'b1, learns_id: 1'b0};
            K_CFG_RD0: info = '{needs_cpl: 1'b1, supported: 1'b1, with_data: 1'b1, learns_id: 1'b0};
            K_CFG_WR0: info = '{needs_cpl: 1'b1, supported: 1'b1, with_data: 1'b0, learns_id: 1'b1};
            K_IO_RD:   info = '{needs_cpl: 1'b1, supported: 1'b0, with_data: 1'b0, learns_id: 1'b0};
            K_IO_WR:   info = '{needs_cpl: 1'b1, supported: 1'b0, with_data: 1'b0, learns_id: 1'b0};
            K_MEM_WR:  info = '{needs_cpl: 1'b0, supported: 1'b1, with_data: 1'b0, learns_id: 1'b0};
            K_MSG:     info = '{needs_cpl: 1'b0, supported: 1'b1, with_data: 1'b0, learns_id: 1'b0};
            K_VMSG:    info = '{needs_cpl: 1'b0, supported: 1'b0, with_data: 1'b0, learns_id: 1'b0};
            default:   info = '0;
        endcase
    end
endmodule

// File: rtl/txid_id_reg.sv
module txid_id_reg #(
    parameter int BUS_W = 8,
    parameter int DEV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BUS_W-1:0] bus_in,
    input  logic [DEV_W-1:0] dev_in,
    output logic [BUS_W-1:0] bus_q,
    output logic [DEV_W-1:0] dev_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q <= '0;
            dev_q <= '0;
        end else if (load) begin
            bus_q <= bus_in;
            dev_q <= dev_in;
        end
    end

    // R2: numbers move only on a load, and take the loaded value
    a_r2_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(bus_q) && $stable(dev_q)));
    a_r2_take_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (bus_q == $past(bus_in) && dev_q == $past(dev_in)));
endmodule

// File: rtl/txid_cpl_fsm.sv
module txid_cpl_fsm
    import txid_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int DEV_W  = 5,
    parameter int FN_W   = 3,
    parameter int TAG_W  = 8,
    parameter int ATTR_W = 2,
    parameter int TC_W   = 3,
    localparam int ID_W  = BUS_W + DEV_W + FN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  kind_info_t        info,
    input  logic [ID_W-1:0]   req_rid,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [ATTR_W-1:0] req_attr,
    input  logic [TC_W-1:0]   req_tc,
    input  logic [BUS_W-1:0]  cfg_bus,
    input  logic [DEV_W-1:0]  cfg_dev,
    input  logic [BUS_W-1:0]  bus_q,
    input  logic [DEV_W-1:0]  dev_q,
    input  logic [FN_W-1:0]   func_num,
    output logic              id_load,
    output logic              cpl_valid,
    input  logic              cpl_ready,
    output logic [ID_W-1:0]   cpl_cid,
    output logic [ID_W-1:0]   cpl_rid,
    output logic [TAG_W-1:0]  cpl_tag,
    output logic [ATTR_W-1:0] cpl_attr,
    output logic [TC_W-1:0]   cpl_tc,
    output logic [2:0]        cpl_status,
    output logic              cpl_has_data
);
    cpl_state_e state_q, state_d;
    logic       accept;
    logic       take_np;

    assign accept  = req_valid && req_ready;
    assign take_np = accept && info.needs_cpl;
    assign id_load = accept && info.learns_id;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (take_np) state_d = S_HOLD;
            S_HOLD:  if (cpl_ready) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        req_ready = (state_q == S_IDLE);
        cpl_valid = (state_q == S_HOLD);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpl_cid      <= '0;
            cpl_rid      <= '0;
            cpl_tag      <= '0;
            cpl_attr     <= '0;
            cpl_tc       <= '0;
            cpl_status   <= CST_SC;
            cpl_has_data <= 1'b0;
        end else if (take_np) begin
            cpl_cid      <= info.learns_id ? {cfg_bus, cfg_dev, func_num}
                                           : {bus_q, dev_q, func_num};
            cpl_rid      <= req_rid;
            cpl_tag      <= req_tag;
            cpl_attr     <= req_attr;
            cpl_tc       <= req_tc;
            cpl_status   <= info.supported ? CST_SC : CST_UR;
            cpl_has_data <= info.supported && info.with_data;
        end
    end

    // R8: a non-posted acceptance yields a descriptor next cycle
    a_r8_valid_follows_np: assert property (@(posedge clk) disable iff (!rst_n)
        take_np |=> cpl_valid);
    // R8: no intake while a descriptor is pending
    a_r8_no_intake_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> !req_ready);
    // R6: posted acceptance in idle never raises valid
    a_r6_posted_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !info.needs_cpl) |=> !cpl_valid);
    // R9: descriptor frozen under backpressure
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_cid) && $stable(cpl_rid)
            && $stable(cpl_tag) && $stable(cpl_attr) && $stable(cpl_tc)
            && $stable(cpl_status) && $stable(cpl_has_data)));
    // R9: handshake retires the descriptor
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_ready) |=> !cpl_valid);
    // R7: an unsupported completion never carries data
    a_r7_ur_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_status == CST_UR) |-> !cpl_has_data);
endmodule

// File: rtl/txid_cpl_top.sv
module txid_cpl_top
    import txid_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int DEV_W  = 5,
    parameter int FN_W   = 3,
    parameter int TAG_W  = 8,
    parameter int ATTR_W = 2,
    parameter int TC_W   = 3,
    localparam int ID_W  = BUS_W + DEV_W + FN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FN_W-1:0]   func_num,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_kind,
    input  logic [ID_W-1:0]   req_rid,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [ATTR_W-1:0] req_attr,
    input  logic [TC_W-1:0]   req_tc,
    input  logic [BUS_W-1:0]  req_cfg_bus,
    input  logic [DEV_W-1:0]  req_cfg_dev,
    output logic [ID_W-1:0]   own_req_id,
    output logic              cpl_valid,
    input  logic              cpl_ready,
    output logic [ID_W-1:0]   cpl_cid,
    output logic [ID_W-1:0]   cpl_rid,
    output logic [TAG_W-1:0]  cpl_tag,
    output logic [ATTR_W-1:0] cpl_attr,
    output logic [TC_W-1:0]   cpl_tc,
    output logic [2:0]        cpl_status,
    output logic              cpl_has_data
);
    kind_info_t       info;
    logic             id_load;
    logic [BUS_W-1:0] bus_q;
    logic [DEV_W-1:0] dev_q;

    txid_classify u_cls (
        .kind (req_kind),
        .info (info)
    );

    txid_id_reg #(.BUS_W(BUS_W), .DEV_W(DEV_W)) u_id (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (id_load),
        .bus_in (req_cfg_bus),
        .dev_in (req_cfg_dev),
        .bus_q  (bus_q),
        .dev_q  (dev_q)
    );

    txid_cpl_fsm #(
        .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W),
        .TAG_W(TAG_W), .ATTR_W(ATTR_W), .TC_W(TC_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .info         (info),
        .req_rid      (req_rid),
        .req_tag      (req_tag),
        .req_attr     (req_attr),
        .req_tc       (req_tc),
        .cfg_bus      (req_cfg_bus),
        .cfg_dev      (req_cfg_dev),
        .bus_q        (bus_q),
        .dev_q        (dev_q),
        .func_num     (func_num),
        .id_load      (id_load),
        .cpl_valid    (cpl_valid),
        .cpl_ready    (cpl_ready),
        .cpl_cid      (cpl_cid),
        .cpl_rid      (cpl_rid),
        .cpl_tag      (cpl_tag),
        .cpl_attr     (cpl_attr),
        .cpl_tc       (cpl_tc),
        .cpl_status   (cpl_status),
        .cpl_has_data (cpl_has_data)
    );

    // R3: the outbound requester ID is the stored identity plus the function
    assign own_req_id = {bus_q, dev_q, func_num};

    // R4: a non-learning completion reports the identity that was published
    a_r4_cid_matches_id: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && info.needs_cpl && !info.learns_id)
            |=> (cpl_cid == $past(own_req_id)));
endmodule

// File: tb/txid_cpl_top_tb_top.sv
module txid_cpl_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  func_num = 3'd5;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_kind = '0;
    logic [15:0] req_rid = '0;
    logic [7:0]  req_tag = '0;
    logic [1:0]  req_attr = '0;
    logic [2:0]  req_tc = '0;
    logic [7:0]  req_cfg_bus = '0;
    logic [4:0]  req_cfg_dev = '0;
    logic [15:0] own_req_id;
    logic        cpl_valid;
    logic        cpl_ready = 1'b0;
    logic [15:0] cpl_cid, cpl_rid;
    logic [7:0]  cpl_tag;
    logic [1:0]  cpl_attr;
    logic [2:0]  cpl_tc, cpl_status;
    logic        cpl_has_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] m_bus = '0;
    logic [4:0] m_dev = '0;

    always #4 clk = ~clk;

    txid_cpl_top dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_desc(input int k, input logic [15:0] rid, input logic [7:0] tag,
                              input logic [1:0] attr, input logic [2:0] tc,
                              input logic [15:0] cid);
        logic np, sup, dat;
        np  = !(k == 1 || k == 4 || k == 7);
        sup = (k == 0 || k == 2 || k == 3);
        dat = (k == 0 || k == 2);
        chk("R8 valid", {31'd0, cpl_valid}, 32'd1);
        chk("R8 ready low", {31'd0, req_ready}, 32'd0);
        chk("R4 cid", {16'd0, cpl_cid}, {16'd0, cid});
        chk("R5 echo", {cpl_rid, cpl_tag, cpl_attr, cpl_tc, 3'd0},
                       {rid, tag, attr, tc, 3'd0});
        chk("R7 status", {29'd0, cpl_status}, sup ? 32'd0 : 32'd1);
        chk("R7 data", {31'd0, cpl_has_data}, {31'd0, dat && np});
    endtask

    task automatic send(input int k, input logic [15:0] rid, input logic [7:0] tag,
                        input logic [1:0] attr, input logic [2:0] tc,
                        input logic [7:0] b, input logic [4:0] d, input int stall);
        logic np;
        logic [15:0] cid;
        np = !(k == 1 || k == 4 || k == 7);
        cid = (k == 3) ? {b, d, func_num} : {m_bus, m_dev, func_num};
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'(k); req_rid = rid; req_tag = tag;
        req_attr = attr; req_tc = tc; req_cfg_bus = b; req_cfg_dev = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (k == 3) begin m_bus = b; m_dev = d; end
        chk("R2 R3 own id", {16'd0, own_req_id}, {16'd0, m_bus, m_dev, func_num});
        if (np) begin
            check_desc(k, rid, tag, attr, tc, cid);
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                check_desc(k, rid, tag, attr, tc, cid);   // R9 held
            end
            cpl_ready = 1'b1;
            @(negedge clk);
            cpl_ready = 1'b0;
            chk("R9 released", {31'd0, cpl_valid}, 32'd0);
            chk("R8 ready back", {31'd0, req_ready}, 32'd1);
        end else begin
            chk("R6 posted silent", {31'd0, cpl_valid}, 32'd0);
            chk("R6 ready kept", {31'd0, req_ready}, 32'd1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 own id", {16'd0, own_req_id}, {16'd0, 13'd0, func_num});
        chk("R1 valid", {31'd0, cpl_valid}, 32'd0);
        chk("R1 ready", {31'd0, req_ready}, 32'd1);
        for (int k = 0; k < 8; k++) begin
            for (int t = 0; t < 8; t++) begin
                send(k, 16'(16'hA000 + k * 257 + t * 31), 8'(k * 8 + t), 2'(t), 3'(t),
                     8'(k * 37 + t * 11 + 1), 5'((t * 3 + k) % 32), t % 3);
            end
        end
        // R2: config write back to back with a read that must use the new identity
        send(3, 16'h1234, 8'hFE, 2'd3, 3'd7, 8'hC3, 5'd31, 0);
        send(0, 16'h4321, 8'h01, 2'd0, 3'd6, 8'h00, 5'd0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule